// File: doc/BRIEF.md
# High-Speed Handshake Negotiator for a USB Device Port

This block sits in the link layer of a device that can run at high speed. The device starts out attached as full speed with its D+ pull-up enabled. The block then watches the sampled line state for a held single-ended zero, which marks a bus reset. Once it sees one, it asks the transceiver to drive a chirp K back to the host for a fixed time. It then counts the alternating K and J chirps that a high-speed host returns.

Once enough complete K-then-J pairs have arrived, the block switches to high speed. It drops the full-speed pull-up and enables high-speed termination in the same clock. If the host stays silent past a timeout, the block falls back to full speed and keeps the pull-up on.

All timing is counted in pulses of a one-cycle tick strobe, nominally one per microsecond. Every duration is a tick-count parameter. The pins are plain control and status levels. There is no data stream, so there is no flow control.

Top module: `usbneg_hs_negotiator`

## Requirements
- R1: After reset, and whenever `rst_n` is low, the outputs are: `pullup_en`=1, `chirp_k_drv`=0, `hs_term_en`=0 and `speed_mode`=2'b00 (full speed).
- R2: In the full-speed state, a single-ended zero (`line_state`=2'b00) held for fewer than `RST_SE0_TICKS` ticks starts nothing. Any other line value restarts the measurement.
- R3: In the full-speed state, a single-ended zero held for `RST_SE0_TICKS` ticks starts the handshake. The outputs become `chirp_k_drv`=1 and `speed_mode`=2'b01 (negotiating), and `pullup_en` stays 1.
- R4: The chirp K request is held for `DEV_CHIRP_TICKS` ticks and is then released while `speed_mode` stays 2'b01. The line state has no effect while the request is held. `chirp_k_drv` is never 1 outside mode 2'b01.
- R5: After the device chirp, a host K (`line_state`=2'b10) or J (2'b01) counts only once it has been held for `HOST_CHIRP_MIN_TICKS` ticks. A valid K followed by a valid J makes one pair.
- R6: A K or J that ends before reaching the minimum hold time clears the pair count. The pairs seen before it then no longer count toward high speed.
- R7: When the pair count reaches `KJ_PAIRS_NEEDED`, the block enters high speed. In one clock `pullup_en` falls and `hs_term_en` rises, and `speed_mode` becomes 2'b10. `pullup_en` and `hs_term_en` are never equal.
- R8: If the pairs are not complete within `HS_WAIT_TICKS` ticks after the chirp ends, the block returns to full speed (mode 2'b00) with `pullup_en`=1.
- R9: High speed is held until `rst_n` goes low, whatever the line state does.
- R10: After a fallback to full speed, a new long single-ended zero starts a fresh handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base strobe, nominally 1 µs |
| line_state | input | 2 | Sampled bus level: 00 SE0, 01 J, 10 K, 11 SE1 |
| pullup_en | output | 1 | Full-speed D+ pull-up enable |
| chirp_k_drv | output | 1 | Request to drive chirp K |
| hs_term_en | output | 1 | High-speed termination enable |
| speed_mode | output | 2 | 00 full speed, 01 negotiating, 10 high speed |

## Verification
Several properties are checked on every cycle by the assertions. The pull-up and the high-speed termination are always exclusive. The chirp request appears only while negotiating. High speed is sticky. The state machine may leave full speed only when the reset timer has expired, may enter high speed only with the pair target met, and may fall back only on timeout. The pair counter moves by at most one per cycle.

The rest is shown only by the bench's scenarios, because each depends on a chosen line pattern. These are the exact durations of reset detection, the device chirp and the timeout, and the rejection of a short single-ended zero. They also include the loss of progress after a glitch chirp, the indifference of high speed to the line, and a second handshake after fallback.

// File: rtl/usbneg_pkg.sv
package usbneg_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    SPD_FULL  = 2'b00,
    SPD_NEGOT = 2'b01,
    SPD_HIGH  = 2'b10
  } speed_t;

  typedef enum logic [1:0] {
    ST_FS       = 2'b00,
    ST_DEVCHIRP = 2'b01,
    ST_HOSTWAIT = 2'b10,
    ST_HS       = 2'b11
  } neg_state_t;

endpackage

// File: rtl/usbneg_tick_timer.sv
module usbneg_tick_timer #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != CW'(LIMIT))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == CW'(LIMIT));

  // The count moves by at most one per cycle, so expiry is never skipped
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)); // R2

endmodule

// File: rtl/usbneg_chirp_pairs.sv
module usbneg_chirp_pairs
  import usbneg_pkg::*;
#(
  parameter int unsigned MIN_TICKS    = 10,
  parameter int unsigned PAIRS_NEEDED = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  tick,
  input  line_t line,
  output logic  pairs_done
);
  localparam int unsigned RW = $clog2(MIN_TICKS + 1);
  localparam int unsigned PW = $clog2(PAIRS_NEEDED + 1);

  line_t         prev_q;
  logic [RW-1:0] run_q;
  logic          have_k_q;
  logic [PW-1:0] pairs_q;

  logic prev_is_chirp, prev_short, level_change, turns_valid, line_is_chirp;

  always_comb begin
    prev_is_chirp = (prev_q == LS_J) || (prev_q == LS_K);
    line_is_chirp = (line == LS_J) || (line == LS_K);
    prev_short    = (run_q != RW'(MIN_TICKS));
    level_change  = (line != prev_q);
    turns_valid   = !level_change && tick && (run_q == RW'(MIN_TICKS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= LS_SE0;
      run_q    <= '0;
      have_k_q <= 1'b0;
      pairs_q  <= '0;
    end else if (!en) begin
      prev_q   <= LS_SE0;
      run_q    <= '0;
      have_k_q <= 1'b0;
      pairs_q  <= '0;
    end else if (level_change) begin
      prev_q <= line;
      run_q  <= '0;
      if (prev_is_chirp && prev_short) begin
        pairs_q  <= '0;
        have_k_q <= 1'b0;
      end else if (!line_is_chirp) begin
        have_k_q <= 1'b0;
      end
    end else begin
      if (tick && prev_short) begin
        run_q <= run_q + 1'b1;
      end
      if (turns_valid) begin
        if (line == LS_K) begin
          have_k_q <= 1'b1;
        end else if ((line == LS_J) && have_k_q) begin
          have_k_q <= 1'b0;
          if (pairs_q != PW'(PAIRS_NEEDED)) begin
            pairs_q <= pairs_q + 1'b1;
          end
        end
      end
    end
  end

  assign pairs_done = (pairs_q == PW'(PAIRS_NEEDED));

  AST_PAIRS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (pairs_q == '0) || (pairs_q == $past(pairs_q))
           || (pairs_q == $past(pairs_q) + 1'b1)); // R5

  AST_GLITCH_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && level_change && prev_is_chirp && prev_short) |=> !pairs_done); // R6

endmodule

// File: rtl/usbneg_hs_negotiator.sv
module usbneg_hs_negotiator
  import usbneg_pkg::*;
#(
  parameter int unsigned RST_SE0_TICKS        = 3,
  parameter int unsigned DEV_CHIRP_TICKS      = 1000,
  parameter int unsigned HOST_CHIRP_MIN_TICKS = 10,
  parameter int unsigned KJ_PAIRS_NEEDED      = 3,
  parameter int unsigned HS_WAIT_TICKS        = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] line_state,
  output logic       pullup_en,
  output logic       chirp_k_drv,
  output logic       hs_term_en,
  output logic [1:0] speed_mode
);
  line_t      line;
  neg_state_t state_q, state_d;
  logic       se0_done, chirp_done, wait_done, pairs_done;

  assign line = line_t'(line_state);

  // Bus reset detection: only measured in full speed, restarted by any non-SE0 level
  usbneg_tick_timer #(.LIMIT(RST_SE0_TICKS)) u_se0_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  ((state_q != ST_FS) || (line != LS_SE0)),
    .tick   (tick),
    .expired(se0_done)
  );

  // Length of the device chirp K
  usbneg_tick_timer #(.LIMIT(DEV_CHIRP_TICKS)) u_chirp_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (state_q != ST_DEVCHIRP),
    .tick   (tick),
    .expired(chirp_done)
  );

  // Window for the host reply
  usbneg_tick_timer #(.LIMIT(HS_WAIT_TICKS)) u_wait_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (state_q != ST_HOSTWAIT),
    .tick   (tick),
    .expired(wait_done)
  );

  usbneg_chirp_pairs #(
    .MIN_TICKS   (HOST_CHIRP_MIN_TICKS),
    .PAIRS_NEEDED(KJ_PAIRS_NEEDED)
  ) u_pairs (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (state_q == ST_HOSTWAIT),
    .tick      (tick),
    .line      (line),
    .pairs_done(pairs_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FS:       if (se0_done)   state_d = ST_DEVCHIRP;
      ST_DEVCHIRP: if (chirp_done) state_d = ST_HOSTWAIT;
      ST_HOSTWAIT: begin
        if (pairs_done)     state_d = ST_HS;
        else if (wait_done) state_d = ST_FS;
      end
      ST_HS:       state_d = ST_HS;
      default:     state_d = ST_FS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FS;
    else        state_q <= state_d;
  end

  always_comb begin
    pullup_en   = (state_q != ST_HS);
    hs_term_en  = (state_q == ST_HS);
    chirp_k_drv = (state_q == ST_DEVCHIRP);
    unique case (state_q)
      ST_FS:                   speed_mode = SPD_FULL;
      ST_DEVCHIRP, ST_HOSTWAIT: speed_mode = SPD_NEGOT;
      default:                 speed_mode = SPD_HIGH;
    endcase
  end

  AST_TERM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_en != hs_term_en); // R7

  AST_CHIRP_ONLY_NEGOT: assert property (@(posedge clk) disable iff (!rst_n)
    chirp_k_drv |-> (speed_mode == SPD_NEGOT)); // R4

  AST_RESET_NEEDS_SE0: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FS) && !se0_done) |=> (state_q == ST_FS)); // R3

  AST_HS_NEEDS_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_HOSTWAIT) && !pairs_done) |=> (state_q != ST_HS)); // R7

  AST_FALLBACK_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_HOSTWAIT) && !wait_done) |=> (state_q != ST_FS)); // R8

  AST_HS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HS) |=> (state_q == ST_HS)); // R9

endmodule

// File: tb/test_usbneg_hs_negotiator.sv
module test_usbneg_hs_negotiator;
  localparam int unsigned RST_T   = 3;
  localparam int unsigned CHIRP_T = 20;
  localparam int unsigned MIN_T   = 3;
  localparam int unsigned PAIRS   = 3;
  localparam int unsigned WAIT_T  = 80;
  localparam int unsigned HOLD    = 20;  // cycles per host chirp (5 ticks)

  localparam logic [4:0] O_FS    = 5'b1_0_0_00;
  localparam logic [4:0] O_CHIRP = 5'b1_1_0_01;
  localparam logic [4:0] O_WAIT  = 5'b1_0_0_01;
  localparam logic [4:0] O_HS    = 5'b0_0_1_10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] line_state = 2'b01;
  logic       pullup_en, chirp_k_drv, hs_term_en;
  logic [1:0] speed_mode;

  int compared = 0;
  int mismatched = 0;
  logic mon_en = 1'b0;
  logic done = 1'b0;
  logic [4:0] last_seen;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  usbneg_hs_negotiator #(
    .RST_SE0_TICKS       (RST_T),
    .DEV_CHIRP_TICKS     (CHIRP_T),
    .HOST_CHIRP_MIN_TICKS(MIN_T),
    .KJ_PAIRS_NEEDED     (PAIRS),
    .HS_WAIT_TICKS       (WAIT_T)
  ) i_usbneg_hs_negotiator (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .line_state (line_state),
    .pullup_en  (pullup_en),
    .chirp_k_drv(chirp_k_drv),
    .hs_term_en (hs_term_en),
    .speed_mode (speed_mode)
  );

  function automatic logic [4:0] outs();
    return {pullup_en, chirp_k_drv, hs_term_en, speed_mode};
  endfunction

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // Monitor: every output change must match the next expected item
  always @(negedge clk) begin
    if (mon_en && !done) begin
      if (outs() !== last_seen) begin
        compared++;
        if (exp_q.size() == 0) begin
          mismatched++;
          $display("FAIL unexpected change: actual %b expected %b (no change due, R2/R4/R9)",
                   outs(), last_seen);
        end else begin
          if (outs() !== exp_q[0]) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b", tag_q[0], outs(), exp_q[0]);
          end
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
        last_seen = outs();
      end
    end
  end

  task automatic push(input logic [4:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic drain(input int max_cycles, input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < max_cycles) begin
      @(negedge clk);
      n++;
    end
    if (exp_q.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL %s: actual %b expected %b (not reached in %0d cycles)",
               tag, outs(), exp_q[0], max_cycles);
      exp_q.delete();
      tag_q.delete();
      last_seen = outs();
    end
  endtask

  task automatic check(input logic [4:0] v, input string tag);
    compared++;
    if (outs() !== v) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", tag, outs(), v);
    end
  endtask

  task automatic drive(input logic [1:0] ls, input int cycles);
    line_state = ls;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic host_pair();
    drive(2'b10, HOLD);
    drive(2'b01, HOLD);
  endtask

  // Bus reset followed by the full device chirp
  task automatic bus_reset(input string tag);
    drive(2'b00, 8);
    check(O_FS, "R2 SE0 still short");
    push(O_CHIRP, tag);
    drain(4 * RST_T + 8, tag);
    push(O_WAIT, "R4 chirp release");
    drive(2'b01, 4 * (CHIRP_T - 3));   // line ignored while chirping (R4)
    check(O_CHIRP, "R4 chirp still held");
    line_state = 2'b00;
    drain(16, "R4 chirp release");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(O_FS, "R1 reset state");
    rst_n = 1'b1;
    last_seen = outs();
    mon_en = 1'b1;
    check(O_FS, "R1 after release");

    // R2: brief SE0 then idle J
    drive(2'b00, 8);
    drive(2'b01, 20);
    drive(2'b00, 4);
    drive(2'b11, 12);
    check(O_FS, "R2 short SE0 ignored");

    // R3/R4/R5/R7: successful handshake
    bus_reset("R3 reset to chirp");
    host_pair();
    host_pair();
    check(O_WAIT, "R5 two pairs not enough");
    push(O_HS, "R7 enter high speed");
    drive(2'b10, HOLD);
    line_state = 2'b01;
    drain(4 * MIN_T + 12, "R7 enter high speed");
    check(O_HS, "R7 pullup off with hs termination");

    // R9: line activity in high speed
    drive(2'b00, 60);
    drive(2'b10, 20);
    drive(2'b01, 20);
    check(O_HS, "R9 high speed held");

    // R1: mid-run reset
    push(O_FS, "R1 reset from high speed");
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drain(4, "R1 reset from high speed");
    line_state = 2'b01;
    repeat (4) @(negedge clk);

    // R8: silent host, fallback
    bus_reset("R3 second reset");
    push(O_FS, "R8 fallback");
    repeat (4 * (WAIT_T - 2)) @(negedge clk);
    check(O_WAIT, "R8 still waiting before timeout");
    drain(16, "R8 fallback");
    check(O_FS, "R8 pullup kept at full speed");

    // R10/R6: fresh handshake with a glitch in the host chirps
    line_state = 2'b01;
    repeat (8) @(negedge clk);
    bus_reset("R10 new handshake after fallback");
    host_pair();
    host_pair();
    drive(2'b10, 4);                   // short K glitch
    drive(2'b01, HOLD);
    host_pair();
    host_pair();
    check(O_WAIT, "R6 glitch cleared earlier pairs");
    push(O_HS, "R6 third pair after glitch");
    drive(2'b10, HOLD);
    line_state = 2'b01;
    drain(4 * MIN_T + 12, "R6 third pair after glitch");
    check(O_HS, "R7 high speed after glitch recovery");

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule